// File: doc/BRIEF.md
# External Bus Hold Arbiter with Refresh Scheduler

The block decides who owns the external memory bus: the local SDRAM access sequencer, or an outside master that asks for the bus with a level request and waits for a grant. It also paces the periodic auto-refresh commands the SDRAM needs. A down-counter set from a programmable period produces refresh ticks. Ticks that have not yet been served are kept in a small owed counter, and the sequencer is asked to run them one at a time through a request/accept pair.

The request from the outside master is asynchronous and is synchronized before use. Software can mask all grants with a lock bit while it keeps watching a status bit that shows whether a request is waiting. Refreshes never stop while such a masked request waits. A request is never lost, whether it arrives in the same cycle as a refresh command or in the middle of a burst. While the outside master owns the bus, refresh ticks are only counted. They are served back to back when the bus comes back.

Top module: `sdram_hold_refresh_arb`

## Requirements
- R1: While reset is active and in the first cycle after it, `hold_ack`, `refresh_req`, `hold_status` and `bus_release` are all 0.
- R2: `hold_status` follows `hold_req_async` through a two-stage synchronizer. A level that is stable before a rising edge shows on `hold_status` after the second rising edge.
- R3: While `cfg_nohold` is 1, `hold_ack` never rises, and `hold_status` still shows a waiting request. When `cfg_nohold` clears, a waiting request is granted without being raised again.
- R4: With `cfg_refresh_en` at 1, a refresh tick occurs every `cfg_refresh_period`+1 cycles. When the sequencer accepts each request in the cycle it is raised, consecutive accepts are exactly `cfg_refresh_period`+1 cycles apart.
- R5: With `cfg_refresh_en` at 0, no new refresh is owed, so `refresh_req` stays 0 once the owed count has drained.
- R6: While a request waits masked by `cfg_nohold`, refresh accepts keep the interval of R4.
- R7: A request that arrives in the same cycle as a refresh accept is still registered and later granted.
- R8: `hold_ack` never rises after a cycle in which `burst_busy` was 1. A request that waits during a burst is granted at the first rising edge at which `burst_busy` is 0.
- R9: `hold_ack` rises only after the owed refresh count is zero. Owed refreshes are issued before the grant, and the grant follows on the next idle edge.
- R10: Once raised, `hold_ack` stays 1 until `hold_status` has been sampled at 0, and it falls on the rising edge after that.
- R11: While `hold_ack` is 1, `refresh_req` is 0 and ticks are counted, up to 8. After the release, `refresh_req` stays 1 and one refresh is accepted every cycle until the count is empty.
- R12: `bus_release` is 1 when `hold_ack` is 1, or when `hold_status` is 1 and `cfg_nohold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_req_async | input | 1 | Bus request from the outside master, asynchronous |
| burst_busy | input | 1 | Sequencer is inside a burst |
| cfg_nohold | input | 1 | Lock bit: masks every grant |
| cfg_refresh_en | input | 1 | Enables refresh ticks |
| cfg_refresh_period | input | PERIOD_W | Reload value of the refresh down-counter |
| refresh_ack | input | 1 | Sequencer accepts the pending refresh |
| refresh_req | output | 1 | A refresh is owed and the bus is held locally |
| hold_ack | output | 1 | Bus granted to the outside master |
| bus_release | output | 1 | Tells the sequencer to stop starting bursts |
| hold_status | output | 1 | Synchronized request level, for software polling |

## Verification
A change on the request pin shows on `hold_status` two rising edges later. A grant follows one edge after all of its conditions hold, and a release follows one edge after the synchronized request drops. An owed refresh raises `refresh_req` one edge after its tick, and `bus_release` follows the lock bit in the same cycle. A behavioural model in the bench is advanced on every rising edge from the same inputs. All four outputs are compared against it in the middle of each low phase, after the inputs have settled. The directed checks wait exactly these edge counts before sampling, including the refresh intervals and the drain run after a hold.

// File: rtl/sdram_arb_pkg.sv
package sdram_arb_pkg;

   localparam int unsigned ARB_PERIOD_W_DEF = 12;
   localparam int unsigned ARB_OWED_MAX_DEF = 8;
   localparam int unsigned ARB_SYNC_DEF     = 2;

   // Saturating owed-refresh update: +1 per tick, -1 per accept.
   function automatic int unsigned owed_step(input int unsigned cur,
                                             input bit inc,
                                             input bit dec,
                                             input int unsigned lim);
      int unsigned nxt;
      nxt = cur;
      if (inc && !dec && cur < lim) nxt = cur + 1;
      if (dec && !inc && cur > 0)   nxt = cur - 1;
      return nxt;
   endfunction

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hold_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stage_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[0] <= 1'b0;
               else        stage_q[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[i] <= 1'b0;
               else        stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import sdram_arb_pkg::*;
#(
   parameter int unsigned PERIOD_W = ARB_PERIOD_W_DEF,
   parameter int unsigned OWED_MAX = ARB_OWED_MAX_DEF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_en,
   input  logic [PERIOD_W-1:0] cfg_period,
   input  logic                bus_granted,
   input  logic                refresh_ack,
   output logic                refresh_req,
   output logic                owed_zero
);

   localparam int unsigned OWED_W = $clog2(OWED_MAX + 1);

   generate
      if (OWED_MAX < 1) begin : g_bad_owed
         $error("refresh_sched: OWED_MAX must be at least 1");
      end
      if (PERIOD_W < 2) begin : g_bad_width
         $error("refresh_sched: PERIOD_W must be at least 2");
      end
   endgenerate

   logic [PERIOD_W-1:0] cnt_q;
   logic [OWED_W-1:0]   owed_q;
   logic                tick;
   logic                accept;

   assign tick   = cfg_en && (cnt_q == '0);
   assign accept = refresh_req && refresh_ack;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!cfg_en) cnt_q <= cfg_period;
      else if (tick)    cnt_q <= cfg_period;
      else              cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) owed_q <= '0;
      else        owed_q <= OWED_W'(owed_step(int'(owed_q), tick, accept, OWED_MAX));
   end

   assign owed_zero   = (owed_q == '0);
   assign refresh_req = !owed_zero && !bus_granted;

   assert_owed_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(owed_q) <= OWED_MAX);

   assert_no_tick_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> owed_q <= $past(owed_q));

   assert_owed_kept_in_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_granted |=> owed_q >= $past(owed_q));

endmodule

// File: rtl/hold_grant.sv
module hold_grant (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_s,
   input  logic cfg_nohold,
   input  logic burst_busy,
   input  logic owed_zero,
   output logic hold_ack,
   output logic bus_release
);

   logic grant_ok;

   assign grant_ok = hold_s && !cfg_nohold && !burst_busy && owed_zero;

   always_ff @(posedge clk) begin
      if (!rst_n)        hold_ack <= 1'b0;
      else if (hold_ack) hold_ack <= hold_s;
      else               hold_ack <= grant_ok;
   end

   assign bus_release = hold_ack || (hold_s && !cfg_nohold);

   assert_no_grant_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack) |-> $past(!cfg_nohold));

   assert_no_grant_midburst_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack) |-> $past(!burst_busy));

   assert_refresh_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack) |-> $past(owed_zero));

   assert_hold_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ack && hold_s) |=> hold_ack);

endmodule

// File: rtl/sdram_hold_refresh_arb.sv
module sdram_hold_refresh_arb
   import sdram_arb_pkg::*;
#(
   parameter int unsigned PERIOD_W    = ARB_PERIOD_W_DEF,
   parameter int unsigned OWED_MAX    = ARB_OWED_MAX_DEF,
   parameter int unsigned SYNC_STAGES = ARB_SYNC_DEF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hold_req_async,
   input  logic                burst_busy,
   input  logic                cfg_nohold,
   input  logic                cfg_refresh_en,
   input  logic [PERIOD_W-1:0] cfg_refresh_period,
   input  logic                refresh_ack,
   output logic                refresh_req,
   output logic                hold_ack,
   output logic                bus_release,
   output logic                hold_status
);

   logic hold_s;
   logic owed_zero;

   hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (hold_req_async),
      .q_sync  (hold_s)
   );

   refresh_sched #(.PERIOD_W(PERIOD_W), .OWED_MAX(OWED_MAX)) u_refresh (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_en      (cfg_refresh_en),
      .cfg_period  (cfg_refresh_period),
      .bus_granted (hold_ack),
      .refresh_ack (refresh_ack),
      .refresh_req (refresh_req),
      .owed_zero   (owed_zero)
   );

   hold_grant u_grant (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_s      (hold_s),
      .cfg_nohold  (cfg_nohold),
      .burst_busy  (burst_busy),
      .owed_zero   (owed_zero),
      .hold_ack    (hold_ack),
      .bus_release (bus_release)
   );

   assign hold_status = hold_s;

   assert_no_refresh_in_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> !refresh_req);

   assert_release_on_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> bus_release);

endmodule

// File: tb/sdram_hold_refresh_arb_tb_top.sv
module sdram_hold_refresh_arb_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int PW = 12;
   localparam int OWED_LIM = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_in = 1'b0;
   logic busy = 1'b0;
   logic nohold = 1'b1;
   logic ref_en = 1'b0;
   logic [PW-1:0] period = PW'(15);
   logic refresh_ack;
   logic refresh_req, hold_ack, bus_release, hold_status;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign refresh_ack = refresh_req & ~busy;

   sdram_hold_refresh_arb #(.PERIOD_W(PW), .OWED_MAX(OWED_LIM), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .hold_req_async(hold_in), .burst_busy(busy),
      .cfg_nohold(nohold), .cfg_refresh_en(ref_en), .cfg_refresh_period(period),
      .refresh_ack(refresh_ack), .refresh_req(refresh_req), .hold_ack(hold_ack),
      .bus_release(bus_release), .hold_status(hold_status)
   );

   // Behavioural reference model
   int m_s1 = 0, m_s2 = 0, m_hack = 0, m_cnt = 0, m_owed = 0;

   function automatic int m_req();
      return (m_owed != 0 && m_hack == 0) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      int tick, acc, nxt;
      cyc++;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_hack = 0; m_cnt = 0; m_owed = 0;
      end else begin
         tick = (ref_en && m_cnt == 0) ? 1 : 0;
         acc  = (m_req() != 0 && !busy) ? 1 : 0;
         nxt  = m_owed + tick - acc;
         if (nxt > OWED_LIM) nxt = OWED_LIM;
         if (m_hack != 0) m_hack = m_s2;
         else m_hack = (m_s2 != 0 && !nohold && !busy && m_owed == 0) ? 1 : 0;
         m_owed = nxt;
         if (!ref_en || m_cnt == 0) m_cnt = int'(period);
         else m_cnt = m_cnt - 1;
         m_s2 = m_s1;
         m_s1 = hold_in ? 1 : 0;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   always begin
      @(negedge clk);
      #1;
      if (!done) begin
         check(int'(hold_ack) == m_hack, "R10 hold_ack vs model", int'(hold_ack), m_hack);
         check(int'(refresh_req) == m_req(), "R11 refresh_req vs model", int'(refresh_req), m_req());
         check(int'(hold_status) == m_s2, "R2 hold_status vs model", int'(hold_status), m_s2);
         check(int'(bus_release) == ((m_hack != 0 || (m_s2 != 0 && !nohold)) ? 1 : 0),
               "R12 bus_release vs model", int'(bus_release),
               (m_hack != 0 || (m_s2 != 0 && !nohold)) ? 1 : 0);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic cyc_n(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic wait_ack(output int at);
      do cyc_n(1); while (!refresh_ack);
      at = cyc;
   endtask

   initial begin
      int t0, t1, acks;
      cyc_n(4);
      check(!hold_ack && !refresh_req && !hold_status && !bus_release, "R1 reset outputs",
            {hold_ack, refresh_req, hold_status, bus_release}, 0);
      rst_n = 1'b1;
      cyc_n(1);
      check(!hold_ack && !refresh_req && !hold_status && !bus_release, "R1 first cycle",
            {hold_ack, refresh_req, hold_status, bus_release}, 0);

      // R4: refresh interval
      ref_en = 1'b1;
      wait_ack(t0);
      wait_ack(t1);
      check(t1 - t0 == 16, "R4 refresh gap", t1 - t0, 16);

      // R2, R3, R6: masked request
      hold_in = 1'b1;
      cyc_n(1);
      check(!hold_status, "R2 status after one edge", hold_status, 0);
      cyc_n(1);
      check(hold_status, "R2 status after two edges", hold_status, 1);
      for (int i = 0; i < 3; i++) begin
         t0 = t1;
         wait_ack(t1);
         check(t1 - t0 == 16, "R6 gap while masked", t1 - t0, 16);
         check(!hold_ack, "R3 no grant while locked", hold_ack, 0);
         check(!bus_release, "R12 no release while locked", bus_release, 0);
      end

      // R3 unlock, R12
      nohold = 1'b0;
      #1;
      check(bus_release, "R12 release on unlock", bus_release, 1);
      cyc_n(2);
      check(hold_ack, "R3 grant after unlock", hold_ack, 1);

      // R10 release timing
      hold_in = 1'b0;
      cyc_n(2);
      check(hold_ack && !hold_status, "R10 ack held until status low", hold_ack, 1);
      cyc_n(1);
      check(!hold_ack, "R10 ack drops", hold_ack, 0);

      // R7: request in the same cycle as a refresh accept
      wait_ack(t0);
      hold_in = 1'b1;
      cyc_n(3);
      check(hold_ack, "R7 coincident request granted", hold_ack, 1);
      hold_in = 1'b0;
      cyc_n(4);

      // R5: refresh off
      ref_en = 1'b0;
      cyc_n(20);
      acks = 0;
      for (int i = 0; i < 50; i++) begin
         cyc_n(1);
         if (refresh_req) acks++;
      end
      check(acks == 0, "R5 no refresh when disabled", acks, 0);

      // R8: request during a burst
      busy = 1'b1;
      hold_in = 1'b1;
      cyc_n(10);
      check(!hold_ack && hold_status, "R8 no grant mid-burst", hold_ack, 0);
      busy = 1'b0;
      cyc_n(1);
      check(hold_ack, "R8 grant at burst end", hold_ack, 1);
      hold_in = 1'b0;
      cyc_n(4);

      // R9: owed refresh and request at the same burst boundary
      ref_en = 1'b1;
      busy = 1'b1;
      cyc_n(34);
      hold_in = 1'b1;
      cyc_n(6);
      busy = 1'b0;
      #1;
      check(refresh_ack, "R9 refresh issued at boundary", refresh_ack, 1);
      cyc_n(1);
      check(!hold_ack, "R9 grant waits for refresh", hold_ack, 0);
      acks = 1;
      for (int i = 0; i < 10 && !hold_ack; i++) begin
         if (refresh_ack) acks++;
         cyc_n(1);
      end
      check(hold_ack, "R9 grant after owed drained", hold_ack, 1);
      check(acks >= 2, "R9 owed refreshes issued first", acks, 2);

      // R11: owed count during hold, drained back to back
      cyc_n(200);
      check(!refresh_req, "R11 no refresh in hold", refresh_req, 0);
      hold_in = 1'b0;
      do cyc_n(1); while (hold_ack);
      for (int i = 0; i < OWED_LIM; i++) begin
         check(refresh_ack, "R11 back-to-back drain", refresh_ack, 1);
         cyc_n(1);
      end
      cyc_n(20);
      finish_run();
   end

endmodule